// File: doc/BRIEF.md
# Reset-Time Serial Boot Preloader

This block fills a window of system RAM from a serial EEPROM before the processor runs at all. From external reset it keeps the processor's active-low reset low. When `start` is raised it becomes the only master of the RAM bus. It opens a mode-0 read on the serial device, which needs only a short fixed command prefix and no address. Then it gathers the returned bit stream eight bits at a time and writes each byte to the next RAM location, counting up from a base address.

After the last location has been written, the block stops the serial clock and raises the device's chip select. It drops its drive enable for the RAM address, data and write lines. One clock later it lets the processor out of reset, so the processor fetches its first instructions from the freshly loaded RAM. A further `start` has no effect until the next external reset. The image length, RAM base, command length, serial clock divider and bit order are all parameters.

Top module: `boot_preload`

## Requirements
- R1: From external reset until the release cycle, `cpu_rst_n` and `done` stay low, and `cpu_rst_n` is never high while `bus_drive` is high.
- R2: Before `start` is seen, `spi_cs_n` is high, `spi_sclk` is low, and `bus_drive` and `ram_we` are low. The released bus outputs `ram_addr` and `ram_data` read zero.
- R3: The clock edge that accepts `start` is called T0, and each later clock edge is numbered t from it. From T0 `spi_cs_n` is low and `spi_sclk` is low. Each half period of `spi_sclk` lasts SCK_HALF system clocks, starting low, so `spi_sclk` equals (t / SCK_HALF) mod 2. `spi_mosi` is high for the first CMD_HIGH = 2 serial clock periods and low after that.
- R4: The first CMD_LEN = 10 serial clock periods carry no data. After them, `spi_miso` is sampled on each falling `spi_sclk` edge. With MSB_FIRST = 1, the first sampled bit of each group of eight becomes bit 7 of the byte.
- R5: Byte number b (from 0) of the stream is written to address BASE_ADDR + b. Exactly N_BYTES = 256 bytes are written, in increasing address order.
- R6: `ram_we` is high for exactly one clock, after the edge at t = 2·SCK_HALF·(CMD_LEN + 8·b + 8) + 1. This is one clock after the eighth bit of byte b is sampled. `ram_addr` is unchanged across the pulse, and `ram_data` is unchanged when the pulse ends.
- R7: The edge after the last write pulse (t = 2·SCK_HALF·(CMD_LEN + 8·N_BYTES) + 2) raises `spi_cs_n` and drops `bus_drive`. The next edge raises `cpu_rst_n` and `done`.
- R8: `start` is ignored while a copy runs and after `done`. Once set, `done` stays high until external reset.
- R9: `spi_sclk` makes no further edges after the last data bit, and it is low whenever `spi_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External active-low reset |
| start | input | 1 | Begins the copy (accepted once per reset) |
| spi_sclk | output | 1 | Serial clock to the EEPROM |
| spi_cs_n | output | 1 | Active-low EEPROM chip select |
| spi_mosi | output | 1 | Command line to the EEPROM |
| spi_miso | input | 1 | Data line from the EEPROM |
| ram_addr | output | ADDR_W | RAM address (zero when released) |
| ram_data | output | 8 | RAM write data (zero when released) |
| ram_we | output | 1 | RAM write strobe, active high |
| bus_drive | output | 1 | Enables the external tri-state drivers of the RAM lines |
| cpu_rst_n | output | 1 | Active-low processor reset |
| done | output | 1 | Copy finished and processor released |

## Verification
On every cycle the assertions check these properties: the processor is never released while the bus is driven, every write strobe is a single clock with a steady address, the address steps by one between writes, the serial clock idles low while the device is deselected, the command line stays low after the prefix, and `done` is sticky. The exact cycle of each strobe, the byte value taken from the serial stream, and the order of the release steps can only be shown by the bench's scenarios. The same holds for `start` being ignored mid-copy and after completion. The bench compares these against a timeline model and a behavioural EEPROM over two full copies with different images.

// File: rtl/bpl_pkg.sv
`timescale 1ns/1ps
package bpl_pkg;
   typedef enum logic [1:0] {
      LD_IDLE = 2'd0,
      LD_RUN  = 2'd1,
      LD_FIN  = 2'd2,
      LD_DONE = 2'd3
   } ld_state_t;

   localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/bpl_spi_seq.sv
`timescale 1ns/1ps
module bpl_spi_seq #(
   parameter int unsigned SCK_HALF = 2,
   parameter int unsigned CMD_LEN  = 10,
   parameter int unsigned CMD_HIGH = 2,
   parameter int unsigned N_BYTES  = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   input  logic finish,
   output logic sclk,
   output logic cs_n,
   output logic mosi,
   output logic data_tick
);
   localparam int unsigned TOT   = CMD_LEN + 8 * N_BYTES;
   localparam int unsigned BIT_W = $clog2(TOT + 1);
   localparam int unsigned DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
   localparam logic [BIT_W-1:0] TOT_C  = BIT_W'(TOT);
   localparam logic [BIT_W-1:0] CMD_C  = BIT_W'(CMD_LEN);
   localparam logic [BIT_W-1:0] HIGH_C = BIT_W'(CMD_HIGH);

   logic [DIV_W-1:0] div_q;
   logic [BIT_W-1:0] bit_q;
   logic             half_end;
   logic             active;

   // Divider: SCK_HALF == 1 needs no counter, every clock ends a half period
   generate
      if (SCK_HALF == 1) begin : g_div_none
         assign half_end = 1'b1;
      end else begin : g_div_cnt
         localparam logic [DIV_W-1:0] DIV_MAX = DIV_W'(SCK_HALF - 1);
         assign half_end = (div_q == DIV_MAX);
      end
   endgenerate

   assign active    = !cs_n && (bit_q < TOT_C);
   assign data_tick = active && half_end && sclk && (bit_q >= CMD_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_n  <= 1'b1;
         sclk  <= 1'b0;
         mosi  <= 1'b0;
         div_q <= '0;
         bit_q <= '0;
      end else if (launch) begin
         cs_n  <= 1'b0;
         sclk  <= 1'b0;
         mosi  <= (CMD_HIGH > 0);
         div_q <= '0;
         bit_q <= '0;
      end else if (finish) begin
         cs_n <= 1'b1;
         mosi <= 1'b0;
      end else if (active) begin
         if (half_end) begin
            div_q <= '0;
            sclk  <= ~sclk;
            if (sclk) begin
               bit_q <= bit_q + BIT_W'(1);
               mosi  <= ((bit_q + BIT_W'(1)) < HIGH_C);
            end
         end else begin
            div_q <= div_q + DIV_W'(1);
         end
      end
   end

   p_sclk_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);
   p_mosi_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && bit_q >= HIGH_C) |-> !mosi);
   p_sclk_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_q == TOT_C) |=> $stable(sclk));
endmodule

// File: rtl/bpl_byte_asm.sv
`timescale 1ns/1ps
module bpl_byte_asm
   import bpl_pkg::*;
#(
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              tick,
   input  logic              miso,
   output logic              byte_vld,
   output logic [BYTE_W-1:0] byte_q
);
   logic [BYTE_W-1:0] sh_q;
   logic [BYTE_W-1:0] sh_nx;
   logic [2:0]        cnt_q;

   generate
      if (MSB_FIRST) begin : g_msb
         assign sh_nx = {sh_q[BYTE_W-2:0], miso};
      end else begin : g_lsb
         assign sh_nx = {miso, sh_q[BYTE_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q     <= '0;
         cnt_q    <= '0;
         byte_vld <= 1'b0;
         byte_q   <= '0;
      end else if (clr) begin
         cnt_q    <= '0;
         byte_vld <= 1'b0;
      end else if (tick) begin
         sh_q     <= sh_nx;
         cnt_q    <= cnt_q + 3'd1;
         byte_vld <= (cnt_q == 3'd7);
         if (cnt_q == 3'd7) byte_q <= sh_nx;
      end else begin
         byte_vld <= 1'b0;
      end
   end

   p_vld_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |=> !byte_vld);
endmodule

// File: rtl/bpl_copy_ctrl.sv
`timescale 1ns/1ps
module bpl_copy_ctrl
   import bpl_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned BASE_ADDR = 16'h0400,
   parameter int unsigned N_BYTES   = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] byte_in,
   output logic              launch,
   output logic              finish,
   output logic [ADDR_W-1:0] addr,
   output logic [BYTE_W-1:0] data,
   output logic              we,
   output logic              drive,
   output logic              cpu_rst_n,
   output logic              done
);
   localparam logic [ADDR_W-1:0] FIRST_A = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(BASE_ADDR + N_BYTES - 1);

   ld_state_t         state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [BYTE_W-1:0] data_q;
   logic              we_q;
   logic              drv_q;

   assign launch = (state_q == LD_IDLE) && start;
   assign finish = (state_q == LD_RUN) && we_q && !byte_vld && (addr_q == LAST_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= LD_IDLE;
         addr_q    <= '0;
         data_q    <= '0;
         we_q      <= 1'b0;
         drv_q     <= 1'b0;
         cpu_rst_n <= 1'b0;
         done      <= 1'b0;
      end else begin
         case (state_q)
            LD_IDLE: if (start) begin
               state_q <= LD_RUN;
               drv_q   <= 1'b1;
               addr_q  <= FIRST_A;
            end
            LD_RUN: begin
               if (byte_vld) begin
                  we_q   <= 1'b1;
                  data_q <= byte_in;
               end else if (we_q) begin
                  we_q <= 1'b0;
                  if (addr_q == LAST_A) begin
                     state_q <= LD_FIN;
                     drv_q   <= 1'b0;
                  end else begin
                     addr_q <= addr_q + ADDR_W'(1);
                  end
               end
            end
            LD_FIN: begin
               state_q   <= LD_DONE;
               cpu_rst_n <= 1'b1;
               done      <= 1'b1;
            end
            default: state_q <= LD_DONE;
         endcase
      end
   end

   assign addr  = drv_q ? addr_q : '0;
   assign data  = drv_q ? data_q : '0;
   assign we    = drv_q & we_q;
   assign drive = drv_q;

   p_we_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      we_q |=> !we_q);
   p_we_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      we_q |-> $stable(addr_q));
   p_we_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(we_q) |-> $stable(data_q));
   p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(we_q) && state_q == LD_RUN) |-> addr_q == $past(addr_q) + ADDR_W'(1));
   p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (done && !drv_q));
endmodule

// File: rtl/boot_preload.sv
`timescale 1ns/1ps
module boot_preload
   import bpl_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned BASE_ADDR = 16'h0400,
   parameter int unsigned N_BYTES   = 256,
   parameter int unsigned CMD_LEN   = 10,
   parameter int unsigned CMD_HIGH  = 2,
   parameter int unsigned SCK_HALF  = 2,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              spi_sclk,
   output logic              spi_cs_n,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [BYTE_W-1:0] ram_data,
   output logic              ram_we,
   output logic              bus_drive,
   output logic              cpu_rst_n,
   output logic              done
);
   if (N_BYTES < 1 || BASE_ADDR + N_BYTES > (1 << ADDR_W)) begin : g_bad_range
      $error("boot_preload: image does not fit the address space");
   end
   if (CMD_HIGH > CMD_LEN) begin : g_bad_cmd
      $error("boot_preload: command prefix longer than command phase");
   end
   if (SCK_HALF < 1) begin : g_bad_div
      $error("boot_preload: SCK_HALF must be at least 1");
   end

   logic              launch;
   logic              finish;
   logic              data_tick;
   logic              byte_vld;
   logic [BYTE_W-1:0] byte_val;

   bpl_spi_seq #(
      .SCK_HALF (SCK_HALF),
      .CMD_LEN  (CMD_LEN),
      .CMD_HIGH (CMD_HIGH),
      .N_BYTES  (N_BYTES)
   ) u_spi (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .finish    (finish),
      .sclk      (spi_sclk),
      .cs_n      (spi_cs_n),
      .mosi      (spi_mosi),
      .data_tick (data_tick)
   );

   bpl_byte_asm #(
      .MSB_FIRST (MSB_FIRST)
   ) u_asm (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (launch),
      .tick     (data_tick),
      .miso     (spi_miso),
      .byte_vld (byte_vld),
      .byte_q   (byte_val)
   );

   bpl_copy_ctrl #(
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR),
      .N_BYTES   (N_BYTES)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .byte_vld  (byte_vld),
      .byte_in   (byte_val),
      .launch    (launch),
      .finish    (finish),
      .addr      (ram_addr),
      .data      (ram_data),
      .we        (ram_we),
      .drive     (bus_drive),
      .cpu_rst_n (cpu_rst_n),
      .done      (done)
   );

   p_rst_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_drive |-> !cpu_rst_n);
   p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_rst_n) |-> (spi_cs_n && !bus_drive && $past(spi_cs_n)));
   p_cs_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_drive |-> !spi_cs_n);
endmodule

// File: tb/tb_boot_preload.sv
`timescale 1ns/1ps
module tb_boot_preload;
   localparam int ADDR_W = 16;
   localparam int BASE   = 16'h0400;
   localparam int NB     = 256;
   localparam int CMD    = 10;
   localparam int HI     = 2;
   localparam int H      = 2;
   localparam int TBITS  = CMD + 8 * NB;
   localparam int TREL   = 2 * H * TBITS + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic spi_miso = 1'b0;
   logic spi_sclk, spi_cs_n, spi_mosi, ram_we, bus_drive, cpu_rst_n, done;
   logic [ADDR_W-1:0] ram_addr;
   logic [7:0] ram_data;

   boot_preload #(
      .ADDR_W(ADDR_W), .BASE_ADDR(BASE), .N_BYTES(NB),
      .CMD_LEN(CMD), .CMD_HIGH(HI), .SCK_HALF(H), .MSB_FIRST(1'b1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .ram_addr(ram_addr), .ram_data(ram_data), .ram_we(ram_we),
      .bus_drive(bus_drive), .cpu_rst_n(cpu_rst_n), .done(done)
   );

   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   bit mon_en = 1'b0;
   bit [7:0] img [NB];
   bit [7:0] ram [NB];
   int writes = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // EEPROM model: data out on falling clock, after the command phase
   int falls = 0;
   always @(negedge spi_sclk or posedge spi_cs_n) begin
      if (spi_cs_n) falls = 0;
      else begin
         falls++;
         if (falls >= CMD && falls - CMD < 8 * NB)
            spi_miso = img[(falls - CMD) / 8][7 - ((falls - CMD) % 8)];
         else
            spi_miso = 1'b0;
      end
   end

   // Command line seen by the device on each rising clock (R3)
   int rises = 0;
   always @(posedge spi_sclk or posedge spi_cs_n) begin
      if (spi_cs_n) rises = 0;
      else begin
         chk(spi_mosi == (rises < HI), "R3", "mosi at rising sclk", spi_mosi, (rises < HI));
         rises++;
      end
   end

   // Timeline reference: m_t counts clock edges since the accepting edge
   int m_t = -1;
   always @(posedge clk) begin
      if (!rst_n) m_t <= -1;
      else if (m_t < 0 && start) m_t <= 0;
      else if (m_t >= 0 && m_t < TREL + 1) m_t <= m_t + 1;
   end

   always @(negedge clk) begin
      if (mon_en) begin
         bit e_run, e_we, e_sclk;
         int k, b;
         e_run = (m_t >= 0) && (m_t < TREL);
         e_sclk = (m_t >= 0) && (m_t < 2 * H * TBITS) && (((m_t / H) % 2) == 1);
         k = m_t - 1 - 2 * H * CMD;
         e_we = (m_t >= 1) && (k > 0) && (k % (16 * H) == 0) && (k / (16 * H) <= NB);
         b = e_we ? k / (16 * H) - 1 : 0;
         chk(spi_cs_n == !e_run, e_run ? "R3" : "R7", "cs_n", spi_cs_n, !e_run);
         chk(bus_drive == e_run, e_run ? "R1" : "R2", "bus_drive", bus_drive, e_run);
         chk(spi_sclk == e_sclk, "R9", "sclk", spi_sclk, e_sclk);
         chk(ram_we == e_we, "R6", "ram_we", ram_we, e_we);
         chk(cpu_rst_n == (m_t >= TREL + 1), "R1", "cpu_rst_n", cpu_rst_n, (m_t >= TREL + 1));
         chk(done == (m_t >= TREL + 1), "R7", "done", done, (m_t >= TREL + 1));
         if (e_we) begin
            chk(ram_addr == ADDR_W'(BASE + b), "R5", "write address", ram_addr, BASE + b);
            chk(ram_data == img[b], "R4", "write data", ram_data, img[b]);
         end
         if (!e_run) begin
            chk(ram_addr == '0 && ram_data == '0, "R2", "released bus", {ram_addr, ram_data}, 0);
         end
         if (ram_we && bus_drive) begin
            writes++;
            if (ram_addr >= ADDR_W'(BASE) && ram_addr < ADDR_W'(BASE + NB))
               ram[ram_addr - ADDR_W'(BASE)] = ram_data;
         end
      end
   end

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic check_image(input string tag);
      for (int i = 0; i < NB; i++)
         chk(ram[i] == img[i], "R5", tag, ram[i], img[i]);
      chk(writes == NB, "R5", "write count", writes, NB);
   endtask

   task automatic wait_done();
      for (int i = 0; i < TREL + 40 && !done; i++) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < NB; i++) img[i] = 8'(i * 37 + 5);
      cycles(4);
      mon_en = 1'b1;
      cycles(2);
      rst_n = 1'b1;
      cycles(20);
      // R2: idle before start
      chk(!cpu_rst_n && spi_cs_n && !bus_drive && !ram_we, "R2", "idle before start",
          {cpu_rst_n, spi_cs_n, bus_drive, ram_we}, 4'b0100);
      start = 1'b1;
      cycles(1);
      start = 1'b0;
      wait_done();
      chk(done && cpu_rst_n, "R7", "first copy finished", {done, cpu_rst_n}, 2'b11);
      check_image("image A");
      // R8: start after done is ignored
      start = 1'b1;
      cycles(60);
      start = 1'b0;
      cycles(10);
      chk(spi_cs_n && done && !bus_drive, "R8", "start after done",
          {spi_cs_n, done, bus_drive}, 3'b110);
      chk(writes == NB, "R8", "no extra writes", writes, NB);

      // Second run: new image, held start, start pulse mid-copy
      rst_n = 1'b0;
      cycles(3);
      chk(!cpu_rst_n && !done && spi_cs_n, "R1", "state under reset",
          {cpu_rst_n, done, spi_cs_n}, 3'b001);
      for (int i = 0; i < NB; i++) begin
         img[i] = 8'(~i) ^ 8'hA5;
         ram[i] = 8'h00;
      end
      writes = 0;
      rst_n = 1'b1;
      cycles(5);
      start = 1'b1;
      cycles(3);
      start = 1'b0;
      cycles(3000);
      start = 1'b1;
      cycles(2);
      start = 1'b0;
      wait_done();
      chk(done && cpu_rst_n, "R7", "second copy finished", {done, cpu_rst_n}, 2'b11);
      check_image("image B");
      cycles(5);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #500000;
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule